// File: doc/BRIEF.md
# Double-Data-Rate Eight-Bit Deserializer

This block turns a serial input that carries two bits per fast-clock period into 8-bit parallel words. It uses plain fabric registers and no dedicated serializer hardware. One register samples the line on the rising edge and another samples it on the falling edge. This gives two half-rate streams, and each stream feeds its own 4-bit shift register. The rising-edge stream fills the even bit positions of the word and the falling-edge stream fills the odd ones.

The word rate is a quarter of the fast clock rate. The block models the slow word clock inside the fast clock domain as a divide-by-4 enable. When the fourth shift step of a word is done, an output register samples the interleaved shift-register contents on the next enabled edge. It also raises a one-cycle new-word flag and a sticky valid flag. Word framing starts from reset: the first bit sampled on the first rising edge after reset release becomes bit 0 of the first word.

Top module: `ddr_deser8`

## Requirements
- R1: While `rst` is high at a rising edge, `rx_word` is cleared to 0 after that edge, and `rx_valid` and `rx_new` are cleared to 0.
- R2: Counting serial bits from reset release, bit j goes to position j mod 8 of word j div 8. The first bit goes to position 0 and later bits fill ascending positions.
- R3: A bit sampled on a rising edge lands in an even position (0, 2, 4, 6). The bit sampled on the falling edge that follows it lands in the next odd position (1, 3, 5, 7). Walking-one, walking-zero and alternating words therefore come out unchanged.
- R4: Number the rising edges with `rst` low as 1, 2, 3 and so on, where edge 1 samples bit 0. Word k appears on `rx_word` after edge 6+4k and holds until edge 10+4k.
- R5: `rx_valid` is 0 until the first word appears. It then stays 1 until the next reset, and it is 1 whenever `rx_new` is 1.
- R6: `rx_new` is 1 for exactly the one cycle after each word update (after edges 6+4k). Successive pulses are exactly 4 cycles apart.
- R7: A reset in the middle of a word drops the partly assembled word. After release, framing restarts at position 0 of a new first word, with the timing of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast capture clock, four times the word rate |
| rst | input | 1 | Synchronous active-high reset, also sets word framing |
| ser_in | input | 1 | Serial data, one bit per clock edge |
| rx_word | output | 8 | Latched parallel word, bit 0 is the first bit received |
| rx_valid | output | 1 | High from the first complete word on |
| rx_new | output | 1 | One-cycle pulse when `rx_word` takes a new word |

## Verification
The hardest case to reach is a reset that arrives while a word is half assembled. The shift registers then hold a mix of old and new bits, and the framing counter is somewhere inside a word. The bench runs a long stream of walking, alternating and computed words, asserts reset partway through a word, and restarts the stream with a different word set. A reference model that counts edges since release predicts, on every cycle, the exact word, the new-word pulse and the valid flag, so any stale bit or misaligned frame shows up at once.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

  // Framing sequencer states
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,  // in reset, capture registers not yet loaded
    SEQ_FILL = 2'd1,  // shifting, first word not yet finished
    SEQ_RUN  = 2'd2   // at least one word finished
  } seq_state_e;

  // Width of a step counter that counts 0 .. steps-1
  function automatic int unsigned step_cnt_w(input int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction

  // True on the last shift step of a word
  function automatic logic is_last_step(input int unsigned cnt,
                                        input int unsigned steps);
    return (cnt == steps - 1);
  endfunction

endpackage

// File: rtl/ddr_deser_capture.sv
module ddr_deser_capture (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic rise_bit,
  output logic fall_bit
);

  // Rising-edge sample: even-numbered serial bit
  always_ff @(posedge clk) begin
    if (rst) rise_bit <= 1'b0;
    else     rise_bit <= ser_in;
  end

  // Falling-edge sample: odd-numbered serial bit
  always_ff @(negedge clk) begin
    if (rst) fall_bit <= 1'b0;
    else     fall_bit <= ser_in;
  end

endmodule

// File: rtl/ddr_deser_lane.sv
module ddr_deser_lane #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] lane_q
);

  // New bit enters at the top and moves down, so after DEPTH steps
  // the oldest bit sits at index 0.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic nxt;
    if (i == DEPTH - 1) begin : g_top
      assign nxt = bit_in;
    end else begin : g_mid
      assign nxt = lane_q[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)           lane_q[i] <= 1'b0;
      else if (shift_en) lane_q[i] <= nxt;
    end
  end

endmodule

// File: rtl/ddr_deser_frame.sv
module ddr_deser_frame
  import ddr_deser_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic shift_en,
  output logic word_done,
  output logic latch_en
);

  localparam int unsigned CW = step_cnt_w(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  seq_state_e     state;
  logic [CW-1:0]  step_cnt;

  // Capture registers hold a usable pair from the second edge after release
  assign shift_en  = (state != SEQ_HOLD);
  assign word_done = shift_en && is_last_step(int'(step_cnt), STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_HOLD;
      step_cnt <= '0;
    end else begin
      if (state == SEQ_HOLD)  state <= SEQ_FILL;
      else if (word_done)     state <= SEQ_RUN;
      if (shift_en) begin
        if (step_cnt == LAST) step_cnt <= '0;
        else                  step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // Divide-by-STEPS enable standing in for the slow word clock
  always_ff @(posedge clk) begin
    if (rst) latch_en <= 1'b0;
    else     latch_en <= word_done;
  end

endmodule

// File: rtl/ddr_deser8.sv
module ddr_deser8 #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_new
);

  localparam int unsigned LANE_W = WORD_W / 2;

  logic              rise_bit;
  logic              fall_bit;
  logic              shift_en;
  logic              word_done;
  logic              latch_en;
  logic [LANE_W-1:0] even_lane;
  logic [LANE_W-1:0] odd_lane;
  logic [WORD_W-1:0] merged;

  ddr_deser_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .rise_bit (rise_bit),
    .fall_bit (fall_bit)
  );

  ddr_deser_frame #(.STEPS(LANE_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .word_done (word_done),
    .latch_en  (latch_en)
  );

  ddr_deser_lane #(.DEPTH(LANE_W)) u_even (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (rise_bit),
    .lane_q   (even_lane)
  );

  ddr_deser_lane #(.DEPTH(LANE_W)) u_odd (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (fall_bit),
    .lane_q   (odd_lane)
  );

  // Interleave lanes: even lane -> even positions, odd lane -> odd positions
  for (genvar i = 0; i < LANE_W; i++) begin : g_merge
    assign merged[2*i]   = even_lane[i];
    assign merged[2*i+1] = odd_lane[i];
  end

  // Word-rate output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word  <= '0;
      rx_valid <= 1'b0;
      rx_new   <= 1'b0;
    end else begin
      rx_new <= latch_en;
      if (latch_en) begin
        rx_word  <= merged;
        rx_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_deser8_chk.sv
module ddr_deser8_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_new,
  input logic              word_done,
  input logic              latch_en
);

  localparam int unsigned STEPS = WORD_W / 2;
  localparam int unsigned GW    = $clog2(STEPS + 1) + 1;

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (rx_new) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != {GW{1'b1}}) begin
      gap <= gap + 1'b1;
    end
  end

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rx_word == '0 && !rx_valid && !rx_new));

  // R4: the word holds between updates
  a_r4_word_holds: assert property (@(posedge clk) disable iff (rst)
    !rx_new |-> $stable(rx_word));

  // R5: valid stays up once set
  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_valid);

  // R5: a new word is always valid
  a_r5_new_is_valid: assert property (@(posedge clk) disable iff (rst)
    rx_new |-> rx_valid);

  // R6: a finished word reaches the output through the word enable
  a_r6_done_to_latch: assert property (@(posedge clk) disable iff (rst)
    word_done |=> latch_en);

  a_r6_latch_to_new: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> rx_new);

  // R6: pulses are exactly STEPS cycles apart
  a_r6_pulse_spacing: assert property (@(posedge clk) disable iff (rst)
    (rx_new && seen) |-> (gap == GW'(STEPS - 1)));

endmodule

bind ddr_deser8 ddr_deser8_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_word   (rx_word),
  .rx_valid  (rx_valid),
  .rx_new    (rx_new),
  .word_done (word_done),
  .latch_en  (latch_en)
);

// File: tb/sim_ddr_deser8.sv
`timescale 1ns/1ps
module sim_ddr_deser8;

  localparam int NW = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic [7:0] rx_word;
  logic       rx_valid;
  logic       rx_new;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;   // rising edges with rst low since last reset
  int bitpos = 0;   // next serial bit index
  int sel    = 0;   // active word set
  logic [7:0] wset [2][NW];

  always #5 clk = ~clk;

  ddr_deser8 u0 (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .rx_new   (rx_new)
  );

  function automatic logic stream_bit(input int s, input int j);
    if (j / 8 < NW) return wset[s][j/8][j%8];
    return 1'b0;
  endfunction

  function automatic logic [7:0] word_at(input int s, input int k);
    if (k < NW) return wset[s][k];
    return 8'h00;
  endfunction

  // Serial driver: even bits before each rising edge, odd before each falling edge
  always begin
    @(negedge clk); #2;
    if (rst) begin bitpos = 0; ser_in = 1'b0; end
    else begin ser_in = stream_bit(sel, bitpos); bitpos++; end
    @(posedge clk); #2;
    if (!rst) begin ser_in = stream_bit(sel, bitpos); bitpos++; end
  end

  task automatic check(input string tag, input logic ok,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: edge count since release decides every output
  always @(posedge clk) begin
    if (rst) edges = 0;
    else     edges++;
    #4;
    if (edges == 0) begin
      check("R1 word",  rx_word == 8'h00, rx_word, 8'h00);
      check("R1 valid", rx_valid == 1'b0, {7'd0, rx_valid}, 8'h00);
      check("R1 new",   rx_new == 1'b0,   {7'd0, rx_new},   8'h00);
    end else begin
      logic       e_valid;
      logic       e_new;
      logic [7:0] e_word;
      e_valid = (edges >= 6);
      e_new   = e_valid && ((edges - 6) % 4 == 0);
      e_word  = e_valid ? word_at(sel, (edges - 6) / 4) : 8'h00;
      check("R5 valid", rx_valid == e_valid, {7'd0, rx_valid}, {7'd0, e_valid});
      check("R6 new",   rx_new == e_new,     {7'd0, rx_new},   {7'd0, e_new});
      if (sel == 0)
        check("R2/R3/R4 word", rx_word == e_word, rx_word, e_word);
      else
        check("R7 word after mid-word reset", rx_word == e_word, rx_word, e_word);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Set 0: walking ones, alternating, all-zero/all-one, computed words (R3)
    for (int i = 0; i < 8; i++) wset[0][i] = 8'h01 << i;
    wset[0][8] = 8'h55; wset[0][9] = 8'hAA; wset[0][10] = 8'h00; wset[0][11] = 8'hFF;
    for (int i = 12; i < NW; i++) wset[0][i] = 8'((i * 37 + 11) & 8'hFF);
    // Set 1: walking zeros, nibble and alternating patterns
    for (int i = 0; i < 8; i++) wset[1][i] = ~(8'h01 << i);
    wset[1][8] = 8'hAA; wset[1][9] = 8'h55; wset[1][10] = 8'hF0; wset[1][11] = 8'h0F;
    for (int i = 12; i < NW; i++) wset[1][i] = 8'((i * 91 + 5) & 8'hFF);

    repeat (4) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    repeat (NW * 4 + 10) @(posedge clk);
    // Mid-word reset (R7)
    repeat (2) @(posedge clk);
    @(negedge clk); #1; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; sel = 1; rst = 1'b0;
    repeat (NW * 4 + 12) @(posedge clk);
    #6;
    summary();
  end

endmodule